// File: doc/BRIEF.md
# E1 Timeslot-Zero Spare Bit Inserter

This block sits in the transmit path of an E1 link, one byte-wide timeslot per clock, and rewrites the International and National bits of timeslot 0 on their way to the line. A frame-start strobe marks timeslot 0 of each frame. A multiframe-start qualifier marks the first frame of a 16-frame CRC multiframe. From these the block keeps a frame number. That number tells it whether the current frame carries the alignment word (even frames) or not (odd frames), and whether the frame is one of the two that hold spare bits in CRC mode.

An 8-bit setup register holds two International values and five National values. Four mode pins choose among three outcomes for each spare position: the register value goes into it, a far-end error bit taken from an input goes into it, or the backplane bit passes through unchanged. The mode pins are frame generation off, national control off, CRC multiframe on and error indication off. The register and the mode pins are captured at each frame strobe, so a frame never mixes old and new settings. Every byte leaves one cycle after it enters, with its timeslot index and strobe delayed to match.

Top module: `e1_spare_inserter`

## Requirements
- R1: After reset the setup register reads 8'hFF. A write sets all eight bits and they read back as written. Register bits 7:6 are International values A:B, bits 4:0 are National values N4..N0, and bit 5 is kept for read-back but drives nothing.
- R2: With generation on and national control on, register bits 4:0 replace data bits 4:0 of timeslot 0 in every odd frame. Line bit positions 4..8 are data bits 4..0, and data bit 7 is sent first.
- R3: With generation on, national control on and CRC mode off, data bit 7 of timeslot 0 becomes register bit 7 in even frames and register bit 6 in odd frames.
- R4: With generation off, timeslot 0 passes unchanged. With national control off and CRC mode off, timeslot 0 also passes unchanged.
- R5: With generation on, CRC mode on and error indication on, data bit 7 of timeslot 0 in frames 13 and 15 takes the value of `febe_in`, and the register's International bits are not used.
- R6: With generation on, CRC mode on, error indication off and national control on, data bit 7 of timeslot 0 becomes register bit 7 in frame 13 and register bit 6 in frame 15.
- R7: With CRC mode on, error indication off and national control off, data bit 7 in frames 13 and 15 passes unchanged.
- R8: In CRC mode, data bit 7 of timeslot 0 in every frame other than 13 and 15 passes unchanged.
- R9: Timeslots 1..31, and data bits 6:5 of timeslot 0, pass unchanged. Every output, including the index and the strobe, lags its input by exactly one cycle.
- R10: A strobe with `mf_start` high numbers its frame 0. Each further strobe advances the number by one, modulo 16. Frame numbers count from 0, and even numbers are alignment frames.
- R11: A register write or a mode pin change takes effect from the first strobe after it, and not within the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Setup register write enable |
| cfg_wdata | input | 8 | Setup register write value |
| cfg_rdata | output | 8 | Setup register read value |
| gen_off | input | 1 | Frame generation disabled |
| nat_off | input | 1 | National/International control disabled |
| crc_on | input | 1 | CRC multiframe generation enabled |
| febe_off | input | 1 | Far-end error indication disabled |
| febe_in | input | 1 | Far-end error value for frames 13 and 15 |
| ts_data | input | 8 | Incoming timeslot byte, bit 7 sent first |
| ts_idx | input | 5 | Incoming timeslot index 0..31 |
| frm_start | input | 1 | High on timeslot 0 of each frame |
| mf_start | input | 1 | With frm_start, marks multiframe frame 0 |
| out_data | output | 8 | Outgoing timeslot byte |
| out_idx | output | 5 | Outgoing timeslot index |
| out_frm_start | output | 1 | Outgoing frame strobe |

## Verification
The assertions check four things on every cycle: that timeslots other than 0 and the fixed bits of timeslot 0 come through with one cycle of delay, that generation off leaves timeslot 0 untouched, that National values land in odd frames, and that the frame number holds between strobes and restarts at a multiframe mark. Several behaviours can only be shown by the bench's scenarios, because they depend on an ordering of events across a whole frame. These are the choice between register, error input and backplane in frames 13 and 15, the International placement with CRC off, and the rule that a write in mid-frame stays invisible until the next strobe. The bench's model applies all of these to random traffic and compares every output on every clock.

// File: rtl/e1s_pkg.sv
package e1s_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 5;
    localparam int MF_LEN   = 16;
    localparam int FRM_W    = $clog2(MF_LEN);
    localparam int SPARE_HI = 13;
    localparam int SPARE_LO = 15;

    typedef struct packed {
        logic [1:0] si;
        logic [4:0] sn;
    } e1s_cfg_t;

    typedef struct packed {
        logic gen_off;
        logic nat_off;
        logic crc_on;
        logic febe_off;
    } e1s_mode_t;

    localparam e1s_cfg_t  CFG_RST  = '{si: 2'b11, sn: 5'h1F};
    localparam e1s_mode_t MODE_RST = '{gen_off: 1'b1, nat_off: 1'b0,
                                       crc_on: 1'b0, febe_off: 1'b0};

    // Rewrite of one timeslot-0 byte for the given frame number.
    function automatic logic [BYTE_W-1:0] ts0_rewrite(
        input logic [BYTE_W-1:0] din,
        input e1s_cfg_t          cfg,
        input e1s_mode_t         mode,
        input logic [FRM_W-1:0]  frame,
        input logic              febe
    );
        logic [BYTE_W-1:0] d;
        logic              odd;
        logic              hi_sp;
        logic              lo_sp;
        d     = din;
        odd   = frame[0];
        hi_sp = (frame == FRM_W'(SPARE_HI));
        lo_sp = (frame == FRM_W'(SPARE_LO));
        if (!mode.gen_off) begin
            if (odd && !mode.nat_off)
                d[4:0] = cfg.sn;
            if (!mode.crc_on) begin
                if (!mode.nat_off)
                    d[BYTE_W-1] = odd ? cfg.si[0] : cfg.si[1];
            end else if (hi_sp || lo_sp) begin
                if (!mode.febe_off)
                    d[BYTE_W-1] = febe;
                else if (!mode.nat_off)
                    d[BYTE_W-1] = hi_sp ? cfg.si[1] : cfg.si[0];
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/e1s_cfg_reg.sv
module e1s_cfg_reg
    import e1s_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              frm_start,
    input  e1s_mode_t         mode_in,
    output logic [BYTE_W-1:0] rd_data,
    output e1s_cfg_t          cfg_act,
    output e1s_mode_t         mode_act
);
    logic [BYTE_W-1:0] reg_q;
    e1s_cfg_t          live_cfg;
    e1s_cfg_t          sh_cfg_q;
    e1s_mode_t         sh_mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            reg_q <= {BYTE_W{1'b1}};
        else if (wr_en)
            reg_q <= wr_data;
    end

    assign live_cfg.si = reg_q[7:6];
    assign live_cfg.sn = reg_q[4:0];
    assign rd_data     = reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_cfg_q  <= CFG_RST;
            sh_mode_q <= MODE_RST;
        end else if (frm_start) begin
            sh_cfg_q  <= live_cfg;
            sh_mode_q <= mode_in;
        end
    end

    // On the strobe cycle the new frame already uses the fresh values.
    assign cfg_act  = frm_start ? live_cfg : sh_cfg_q;
    assign mode_act = frm_start ? mode_in  : sh_mode_q;

endmodule

// File: rtl/e1s_frame_track.sv
module e1s_frame_track
    import e1s_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic             mf_start,
    output logic [FRM_W-1:0] frame_now,
    output logic [FRM_W-1:0] frame_q
);
    logic [FRM_W-1:0] nxt;

    generate
        if (MF_LEN == (1 << FRM_W)) begin : g_pow2
            assign nxt = frame_q + FRM_W'(1);
        end else begin : g_wrap
            assign nxt = (frame_q == FRM_W'(MF_LEN - 1)) ? '0 : frame_q + FRM_W'(1);
        end
    endgenerate

    always_comb begin
        frame_now = frame_q;
        if (frm_start)
            frame_now = mf_start ? '0 : nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= FRM_W'(MF_LEN - 1);
        else
            frame_q <= frame_now;
    end

endmodule

// File: rtl/e1s_bit_sub.sv
module e1s_bit_sub
    import e1s_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] ts_data,
    input  logic [IDX_W-1:0]  ts_idx,
    input  logic              frm_start,
    input  e1s_cfg_t          cfg_act,
    input  e1s_mode_t         mode_act,
    input  logic [FRM_W-1:0]  frame_now,
    input  logic              febe_in,
    output logic [BYTE_W-1:0] out_data,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_frm_start
);
    logic [BYTE_W-1:0] nxt_data;

    always_comb begin
        nxt_data = ts_data;
        if (ts_idx == '0)
            nxt_data = ts0_rewrite(ts_data, cfg_act, mode_act, frame_now, febe_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data      <= '0;
            out_idx       <= '0;
            out_frm_start <= 1'b0;
        end else begin
            out_data      <= nxt_data;
            out_idx       <= ts_idx;
            out_frm_start <= frm_start;
        end
    end

endmodule

// File: rtl/e1_spare_inserter.sv
module e1_spare_inserter
    import e1s_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic              gen_off,
    input  logic              nat_off,
    input  logic              crc_on,
    input  logic              febe_off,
    input  logic              febe_in,
    input  logic [BYTE_W-1:0] ts_data,
    input  logic [IDX_W-1:0]  ts_idx,
    input  logic              frm_start,
    input  logic              mf_start,
    output logic [BYTE_W-1:0] out_data,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_frm_start
);
    e1s_mode_t        mode_pins;
    e1s_mode_t        mode_act;
    e1s_cfg_t         cfg_act;
    logic [FRM_W-1:0] frame_now;
    logic [FRM_W-1:0] frame_q;

    assign mode_pins = '{gen_off: gen_off, nat_off: nat_off,
                         crc_on: crc_on, febe_off: febe_off};

    e1s_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .wr_data   (cfg_wdata),
        .frm_start (frm_start),
        .mode_in   (mode_pins),
        .rd_data   (cfg_rdata),
        .cfg_act   (cfg_act),
        .mode_act  (mode_act)
    );

    e1s_frame_track u_trk (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .mf_start  (mf_start),
        .frame_now (frame_now),
        .frame_q   (frame_q)
    );

    e1s_bit_sub u_sub (
        .clk           (clk),
        .rst           (rst),
        .ts_data       (ts_data),
        .ts_idx        (ts_idx),
        .frm_start     (frm_start),
        .cfg_act       (cfg_act),
        .mode_act      (mode_act),
        .frame_now     (frame_now),
        .febe_in       (febe_in),
        .out_data      (out_data),
        .out_idx       (out_idx),
        .out_frm_start (out_frm_start)
    );

endmodule

// File: rtl/e1s_checker.sv
module e1s_checker
    import e1s_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BYTE_W-1:0] ts_data,
    input logic [IDX_W-1:0]  ts_idx,
    input logic              frm_start,
    input logic              mf_start,
    input logic [BYTE_W-1:0] out_data,
    input logic [IDX_W-1:0]  out_idx,
    input logic              out_frm_start,
    input logic              act_gen_off,
    input logic              act_nat_off,
    input logic [4:0]        act_sn,
    input logic [FRM_W-1:0]  frame_now,
    input logic [FRM_W-1:0]  frame_q
);
    assert_other_ts_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (ts_idx != '0) |=> (out_data == $past(ts_data)));

    assert_fixed_bits_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (ts_idx == '0) |=> (out_data[6:5] == $past(ts_data[6:5])));

    assert_side_latency_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_idx == $past(ts_idx) && out_frm_start == $past(frm_start)));

    assert_gen_off_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (ts_idx == '0 && act_gen_off) |=> (out_data == $past(ts_data)));

    assert_national_odd_R2: assert property (@(posedge clk) disable iff (rst)
        (ts_idx == '0 && !act_gen_off && !act_nat_off && frame_now[0])
        |=> (out_data[4:0] == $past(act_sn)));

    assert_frame_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!frm_start) |=> $stable(frame_q));

    assert_mf_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (frm_start && mf_start) |=> (frame_q == '0));

endmodule

bind e1_spare_inserter e1s_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .ts_data       (ts_data),
    .ts_idx        (ts_idx),
    .frm_start     (frm_start),
    .mf_start      (mf_start),
    .out_data      (out_data),
    .out_idx       (out_idx),
    .out_frm_start (out_frm_start),
    .act_gen_off   (mode_act.gen_off),
    .act_nat_off   (mode_act.nat_off),
    .act_sn        (cfg_act.sn),
    .frame_now     (frame_now),
    .frame_q       (frame_q)
);

// File: tb/e1_spare_inserter_bench.sv
`timescale 1ns/1ps
module e1_spare_inserter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       gen_off = 1'b1, nat_off = 1'b0, crc_on = 1'b0, febe_off = 1'b0;
    logic       febe_in = 1'b0;
    logic [7:0] ts_data = 8'h00;
    logic [4:0] ts_idx = 5'd1;
    logic       frm_start = 1'b0, mf_start = 1'b0;
    logic [7:0] out_data;
    logic [4:0] out_idx;
    logic       out_frm_start;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int g_f = 0;
    bit started = 0;

    always #4 clk = ~clk;

    e1_spare_inserter u_e1_spare_inserter (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .gen_off(gen_off), .nat_off(nat_off),
        .crc_on(crc_on), .febe_off(febe_off), .febe_in(febe_in),
        .ts_data(ts_data), .ts_idx(ts_idx), .frm_start(frm_start),
        .mf_start(mf_start), .out_data(out_data), .out_idx(out_idx),
        .out_frm_start(out_frm_start)
    );

    // Behavioural model (R10 frame numbering, R11 strobe capture).
    logic [7:0] m_reg, m_sh, e_data;
    logic [4:0] e_idx;
    logic       e_fs;
    logic       m_go, m_no, m_crc, m_fo;
    int         m_cnt;
    string      tag = "R1";

    always @(posedge clk) begin
        logic [7:0] d;
        bit fas;
        started = 1;
        if (rst) begin
            m_reg = 8'hFF; m_sh = 8'hFF; m_cnt = 15;
            m_go = 1; m_no = 0; m_crc = 0; m_fo = 0;
            e_data = 8'h00; e_idx = 5'd0; e_fs = 0; tag = "R1";
        end else begin
            if (frm_start) begin
                m_cnt = mf_start ? 0 : (m_cnt + 1) % 16;
                m_sh = m_reg;
                m_go = gen_off; m_no = nat_off; m_crc = crc_on; m_fo = febe_off;
            end
            d = ts_data;
            tag = "R9";
            if (ts_idx == 0 && !m_go) begin
                fas = (m_cnt % 2 == 0);
                if (!fas && !m_no) begin d[4:0] = m_sh[4:0]; tag = "R2"; end
                if (!m_crc) begin
                    if (!m_no) begin d[7] = fas ? m_sh[7] : m_sh[6]; tag = "R3"; end
                    else tag = "R4";
                end else if (m_cnt == 13 || m_cnt == 15) begin
                    if (!m_fo) begin d[7] = febe_in; tag = "R5"; end
                    else if (!m_no) begin d[7] = (m_cnt == 13) ? m_sh[7] : m_sh[6]; tag = "R6"; end
                    else tag = "R7";
                end else if (tag != "R2") tag = "R8";
            end else if (ts_idx == 0) tag = "R4";
            e_data = d; e_idx = ts_idx; e_fs = frm_start;
            if (cfg_wr) m_reg = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (out_data !== e_data) begin
                errors++;
                $display("FAIL %s out_data actual %h expected %h (frame %0d)", tag, out_data, e_data, m_cnt);
            end
            checks++;
            if (out_idx !== e_idx || out_frm_start !== e_fs) begin
                errors++;
                $display("FAIL R9 idx/strobe actual %0d/%0b expected %0d/%0b", out_idx, out_frm_start, e_idx, e_fs);
            end
            checks++;
            if (cfg_rdata !== m_reg) begin
                errors++;
                $display("FAIL R1 cfg_rdata actual %h expected %h", cfg_rdata, m_reg);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Runs nfr frames; optional register write at frame wf, timeslot wt (R11).
    task automatic run_frames(input int nfr, input int wf, input int wt, input logic [7:0] wv);
        for (int f = 0; f < nfr; f++) begin
            for (int t = 0; t < 32; t++) begin
                @(negedge clk);
                ts_idx    = 5'(t);
                ts_data   = 8'($urandom);
                febe_in   = 1'($urandom);
                frm_start = (t == 0);
                mf_start  = (t == 0) && (g_f % 16 == 0);
                cfg_wr    = (f == wf) && (t == wt);
                cfg_wdata = wv;
            end
            g_f++;
        end
    endtask

    task automatic set_mode(input logic g, input logic n, input logic c, input logic fo);
        gen_off = g; nat_off = n; crc_on = c; febe_off = fo;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;                                   // R1 reset state checked meanwhile
        run_frames(2, -1, 0, 8'h00);               // generation off: R4
        set_mode(0, 0, 0, 0);
        run_frames(32, 0, 5, 8'h95);               // R2, R3, R11 (write mid-frame)
        run_frames(2, 1, 0, 8'h2A);                // R11: write on the strobe cycle
        set_mode(0, 1, 0, 0);
        run_frames(16, -1, 0, 8'h00);              // R4 national control off
        set_mode(0, 0, 1, 0);
        run_frames(32, 3, 17, 8'hC0);              // R5, R8
        set_mode(0, 0, 1, 1);
        run_frames(32, 0, 9, 8'h7F);               // R6
        run_frames(16, 0, 9, 8'hBE);               // R6 with other Si
        set_mode(0, 1, 1, 1);
        run_frames(32, -1, 0, 8'h00);              // R7
        g_f = 0;                                   // R10: early multiframe restart
        set_mode(0, 0, 1, 1);
        run_frames(7, -1, 0, 8'h00);
        g_f = 0;
        run_frames(20, -1, 0, 8'h00);
        set_mode(1, 0, 1, 0);
        run_frames(16, -1, 0, 8'h00);              // R4 generation off in CRC mode
        @(negedge clk);
        ts_idx = 5'd1; frm_start = 0; mf_start = 0; cfg_wr = 0;
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule